// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This controller brings up a set of supply rails in a fixed order. It takes four digital undervoltage flags, one per rail, each high while its rail sits above its trip point. It drives three active-high regulator enables and a power-good flag. Bit 0 of the flag input watches the main input supply. Bits 1 to 3 watch the rails that the controller's own enables switch on. Each enable is granted only once the rail ahead of it has stayed good for a qualification time. Power-good is raised last, after every rail has stayed good for the long qualification time.

Once power-good is up, the controller works as a supervisor, and its fault reactions change. If the main rail drops for longer than the deglitch time, every enable and power-good fall together and sequencing starts again. If a downstream rail drops, only power-good falls. The enables stay on, and power-good returns after a fresh long qualification. Every delay is a parameter counted in clock cycles. Every input passes through a two-flop synchroniser.

Top module: `rail_seq_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the controller in the off state within one clock edge. In the off state `en_o` is 3'b000 and `pgood_o` is 0.
- R2: The outputs only ever show the stage codes {pgood_o, en_o} = 0000 (off), 0001, 0011, 0111 and 1111 (power good).
- R3: From off, 0001 appears on the clock edge LONG_CYC+2 edges after `rail_ok_i[0]` goes high: two for the synchroniser, LONG_CYC for qualification. If the input drops for even one cycle, the count starts again from zero.
- R4: In stage 0001, when `rail_ok_i[0]` and `rail_ok_i[1]` are both high for SHORT_CYC synchronised cycles, the stage becomes 0011. The count starts on entry to the stage.
- R5: In stage 0011, when `rail_ok_i[0]` and `rail_ok_i[2]` are both high for SHORT_CYC synchronised cycles, the stage becomes 0111.
- R6: In stage 0111, when all four flags are high for LONG_CYC synchronised cycles, the stage becomes 1111.
- R7: In any stage other than off, if `rail_ok_i[0]` is low for SHORT_CYC synchronised cycles, the controller goes straight to 0000 on one edge. A main-rail fault takes priority over every other event.
- R8: A low pulse on `rail_ok_i[0]` that lasts fewer than SHORT_CYC cycles has no effect on the outputs.
- R9: In stage 1111, if any of `rail_ok_i[3:1]` is low for SHORT_CYC synchronised cycles, the stage becomes 0111. The controller then returns to 1111 after all four flags are again good for LONG_CYC cycles.
- R10: While power-good is up, the enables do not follow their individual trigger flags. Only a main-rail fault or reset can clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_ok_i | input | 4 | Asynchronous rail-good flags; bit 0 is the main rail |
| en_o | output | 3 | Regulator enables, bit n enables the rail watched by bit n+1 |
| pgood_o | output | 1 | Power-good flag |

## Verification
The assertions assume that the rail flags change no more than once per cycle. They take each flag's value after two flops as the controller's view of that flag. They do not cover metastable sampling. The bench changes the flags only on the falling clock edge and holds each level for whole cycles. This keeps the synchroniser's delay at exactly two edges, so the bench can predict the edge on which each stage change appears. The assertions also assume that reset is held for at least one edge before any flag sequence begins. The bench does this before every scenario that starts from the off state.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_EN1  = 3'd1,
    ST_EN2  = 3'd2,
    ST_EN3  = 3'd3,
    ST_GOOD = 3'd4
  } seq_state_t;

  // {pgood, en[2:0]} for each stage
  function automatic logic [3:0] stage_drive(seq_state_t s);
    case (s)
      ST_EN1:  return 4'b0001;
      ST_EN2:  return 4'b0011;
      ST_EN3:  return 4'b0111;
      ST_GOOD: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  // Qualification is met on the last cycle of an unbroken run
  function automatic logic run_complete(logic cond, logic last);
    return cond && last;
  endfunction

endpackage

// File: rtl/rail_sync.sv
module rail_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end

endmodule

// File: rtl/qual_timer.sv
module qual_timer #(
  parameter int LIM = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic met_o
);
  import rseq_pkg::*;

  localparam int W = (LIM < 2) ? 1 : $clog2(LIM);
  localparam logic [W-1:0] LAST = W'(LIM - 1);

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last = (cnt_q == LAST);
  assign met_o   = run_complete(cond_i, at_last);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!cond_i || met_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R3: the run counter never passes its last value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R3: a break in the condition always restarts the run
  p_break_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_i |=> !met_o || (LIM == 1));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  long_met_i,
  input  logic                  adv_met_i,
  input  logic                  main_flt_i,
  input  logic                  ds_flt_i,
  output rseq_pkg::seq_state_t  st_o
);
  import rseq_pkg::*;

  seq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OFF:  if (long_met_i) st_d = ST_EN1;
      ST_EN1:  if (main_flt_i) st_d = ST_OFF; else if (adv_met_i)  st_d = ST_EN2;
      ST_EN2:  if (main_flt_i) st_d = ST_OFF; else if (adv_met_i)  st_d = ST_EN3;
      ST_EN3:  if (main_flt_i) st_d = ST_OFF; else if (long_met_i) st_d = ST_GOOD;
      ST_GOOD: if (main_flt_i) st_d = ST_OFF; else if (ds_flt_i)   st_d = ST_EN3;
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  // R3: leaving the off state only ever lands in the first stage
  p_off_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |=> (st_q == ST_OFF || st_q == ST_EN1));

  // R9: power good is only ever left towards stage 3 or off
  p_good_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GOOD) |=> (st_q == ST_GOOD || st_q == ST_EN3 || st_q == ST_OFF));

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl #(
  parameter int RAILS     = 4,
  parameter int LONG_CYC  = 23_750_000,
  parameter int SHORT_CYC = 3_750
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAILS-1:0] rail_ok_i,
  output logic [RAILS-2:0] en_o,
  output logic             pgood_o
);
  import rseq_pkg::*;

  localparam int NEN = RAILS - 1;
  localparam logic [NEN-1:0] EN_ALL = '1;

  logic [RAILS-1:0] ok_s;
  seq_state_t       st;

  // Named events for the assertions
  logic long_cond, adv_cond, main_cond, ds_cond;
  logic long_met,  adv_met,  main_flt,  ds_flt;
  logic [3:0] drv;

  rail_sync #(.N(RAILS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(rail_ok_i), .sync_o(ok_s)
  );

  assign long_cond = ((st == ST_OFF) && ok_s[0]) || ((st == ST_EN3) && (&ok_s));
  assign adv_cond  = ok_s[0] && (((st == ST_EN1) && ok_s[1]) ||
                                 ((st == ST_EN2) && ok_s[2]));
  assign main_cond = (st != ST_OFF) && !ok_s[0];
  assign ds_cond   = (st == ST_GOOD) && !(&ok_s[RAILS-1:1]);

  qual_timer #(.LIM(LONG_CYC)) u_long (
    .clk(clk), .rst_n(rst_n), .cond_i(long_cond), .met_o(long_met)
  );
  qual_timer #(.LIM(SHORT_CYC)) u_adv (
    .clk(clk), .rst_n(rst_n), .cond_i(adv_cond), .met_o(adv_met)
  );
  qual_timer #(.LIM(SHORT_CYC)) u_main (
    .clk(clk), .rst_n(rst_n), .cond_i(main_cond), .met_o(main_flt)
  );
  qual_timer #(.LIM(SHORT_CYC)) u_ds (
    .clk(clk), .rst_n(rst_n), .cond_i(ds_cond), .met_o(ds_flt)
  );

  seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .long_met_i(long_met), .adv_met_i(adv_met),
    .main_flt_i(main_flt), .ds_flt_i(ds_flt),
    .st_o(st)
  );

  assign drv     = stage_drive(st);
  assign en_o    = drv[NEN-1:0];
  assign pgood_o = drv[3];

  // R1: the off state drives nothing
  always_comb begin
    if (st == ST_OFF) begin
      p_off_quiet_r1: assert (en_o == '0 && !pgood_o);
    end
  end

  // R2: enables form a thermometer code, power good needs all of them
  p_thermo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o == 3'b000 || en_o == 3'b001 || en_o == 3'b011 || en_o == 3'b111) &&
    (!pgood_o || en_o == EN_ALL));

  // R6: power good rises only after a completed long qualification
  p_pg_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> $past(long_met));

  // R7: a qualified main-rail fault clears everything on one edge
  p_main_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    main_flt |=> (en_o == '0 && !pgood_o));

  // R9: a downstream fault drops power good only
  p_ds_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_flt && !main_flt) |=> (en_o == EN_ALL && !pgood_o));

  // R10: while power good, enables hold unless the main rail faults
  p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood_o && !main_flt) |=> (en_o == EN_ALL));

endmodule

// File: tb/tb_rail_seq_ctrl.sv
module tb_rail_seq_ctrl;

  localparam int LONG  = 20;
  localparam int SHORT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rails = 4'b0000;
  logic [2:0] en;
  logic       pg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rail_seq_ctrl #(.RAILS(4), .LONG_CYC(LONG), .SHORT_CYC(SHORT)) dut (
    .clk(clk), .rst_n(rst_n), .rail_ok_i(rails), .en_o(en), .pgood_o(pg)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [3:0] exp);
    checks++;
    if ({pg, en} !== exp) begin
      errors++;
      $display("FAIL %s: {pgood,en} actual %b expected %b at %0t", req, {pg, en}, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rails = 4'b0000;
    step(3);
    check("R1 held reset", 4'b0000);
    rst_n = 1'b1;
    step(2);
    check("R1 after release", 4'b0000);
  endtask

  task automatic t_long_restart();
    rails = 4'b0001;
    step(LONG - 3);
    check("R3 early", 4'b0000);
    rails = 4'b0000;
    step(1);
    rails = 4'b0001;
    step(LONG + 1);
    check("R3 one edge short", 4'b0000);
    step(1);
    check("R3 exact edge", 4'b0001);
  endtask

  task automatic t_sequence();
    rails = 4'b0011;
    step(SHORT + 1);
    check("R4 one edge short", 4'b0001);
    step(1);
    check("R4 exact edge", 4'b0011);
    rails = 4'b0111;
    step(SHORT + 1);
    check("R5 one edge short", 4'b0011);
    step(1);
    check("R5 exact edge", 4'b0111);
    rails = 4'b1111;
    step(LONG + 1);
    check("R6 one edge short", 4'b0111);
    step(1);
    check("R6 exact edge", 4'b1111);
  endtask

  task automatic t_glitch();
    rails = 4'b1110;
    step(SHORT - 1);
    rails = 4'b1111;
    for (int i = 0; i < SHORT + 4; i++) begin
      step(1);
      check("R8 short main glitch", 4'b1111);
    end
  endtask

  task automatic t_ds_fault();
    rails = 4'b1011;
    step(SHORT + 1);
    check("R9 before fault qualifies", 4'b1111);
    step(1);
    check("R9 pgood only", 4'b0111);
    rails = 4'b1111;
    step(LONG + 1);
    check("R9 requalify short", 4'b0111);
    step(1);
    check("R9 requalified", 4'b1111);
    rails = 4'b1101;
    step(SHORT + 2);
    check("R10 enables kept with trigger low", 4'b0111);
    rails = 4'b1111;
    step(LONG + 2);
    check("R10 back to power good", 4'b1111);
  endtask

  task automatic t_main_fault();
    rails = 4'b1110;
    step(SHORT + 1);
    check("R7 before fault qualifies", 4'b1111);
    step(1);
    check("R7 full shutdown", 4'b0000);
    rails = 4'b1111;
    step(LONG + 2);
    check("R3 restart after fault", 4'b0001);
    step(SHORT - 1);
    check("R4 preexisting one short", 4'b0001);
    step(1);
    check("R4 preexisting", 4'b0011);
    step(SHORT);
    check("R5 preexisting", 4'b0111);
    step(LONG - 1);
    check("R6 one short", 4'b0111);
    step(1);
    check("R6 restored", 4'b1111);
  endtask

  task automatic t_mid_reset();
    rst_n = 1'b0;
    step(1);
    check("R1 reset from power good", 4'b0000);
    rails = 4'b0000;
    step(1);
    rst_n = 1'b1;
    step(2);
    check("R1 stays off", 4'b0000);
  endtask

  initial begin
    t_reset();
    t_long_restart();
    t_sequence();
    t_glitch();
    t_ds_fault();
    t_main_fault();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule